// File: doc/BRIEF.md
# DRAM Open-Page Latency Sequencer

This block sits in front of an on-chip DRAM model and decides how long each access takes. It remembers which DRAM page was used last and how many clock cycles have passed since the last accepted access. When a new request is accepted, the block compares the page field of its address with the stored page. An access is a hit only if the page is open, the field matches, and the access starts soon enough after the previous one. The block then counts out the latency for the access type and pulses a completion strobe.

An open page stays valid only while accesses keep arriving. If the gap between accepted accesses grows past a fixed window, the page goes stale, and the next access is a miss even when its address is in the same page. Writes go to a posted buffer, so a write always completes after a short fixed delay. Its hit/miss classification is still reported, and it still updates the stored page. The block holds no data and models no refresh or cache. It only sequences latency and page state.

Top module: `page_latency_tracker`

## Requirements
- R1: After reset, `busy`, `done` and `pageHit` are low and no page is open, so the first accepted access is a miss.
- R2: The page field is address bits [22:12] (11 bits). A hit requires the field to equal the stored page. Address bits outside [22:12] never affect the classification, and a difference in bit 22 alone causes a miss.
- R3: An accepted read that is a hit raises `done` in the 4th cycle after the acceptance edge (the edge that sees `reqValid` high while `busy` is low).
- R4: An accepted read that is a miss raises `done` in the 8th cycle after the acceptance edge.
- R5: An accepted write raises `done` in the 2nd cycle after the acceptance edge, whether it hits or misses. `pageHit` still reports the write's classification.
- R6: An access is hit-eligible only if its acceptance edge is at most 1024 cycles after the previous acceptance edge. At 1025 cycles or more it is a miss, however long the gap is (the idle count saturates and never wraps).
- R7: Every accepted access, including misses and writes, makes its page field the stored page.
- R8: A request presented while `busy` is high is not accepted. It changes neither the stored page nor the timing or result of the access in flight.
- R9: `busy` is high from the cycle after the acceptance edge through the cycle in which `done` is high, and low in the cycle after that.
- R10: `done` is high for exactly one cycle per access. `pageHit` is high only while `done` is high, and then it gives the access's hit/miss result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Access request; accepted on an edge where `busy` is low |
| reqAddr | input | 32 | Byte address of the access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | An access is in progress; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| pageHit | output | 1 | Hit/miss result, meaningful while `done` is high |

## Verification
Some properties are checked on every cycle. `done` never lasts more than one cycle, and it never appears without `busy`. Each completion arrives exactly as many cycles after acceptance as the latency chosen at acceptance. An in-flight access keeps its result while busy. The idle count never passes the window, and a saturated count never yields a hit. Other behaviour can only be shown by the bench's scenarios: that the chosen latency matches the access type and page state, that a write updates the stored page, and that hammered requests during busy leave the page untouched. The bench also checks the exact 1024/1025-cycle window boundary and that page state is cleared by a mid-run reset.

// File: rtl/page_latency_pkg.sv
package page_latency_pkg;

  // Strobes issued by the control FSM to the page/idle datapath.
  typedef struct packed {
    logic loadPage;     // capture page field of the accepted address
    logic restartIdle;  // restart the inter-access idle count
  } ctrl_strobe_t;

endpackage

// File: rtl/page_latency_dp.sv
module page_latency_dp
  import page_latency_pkg::*;
#(
  parameter int PAGE_W = 11,
  parameter int WINDOW = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [PAGE_W-1:0] pageIn,
  output logic              isHit
);

  localparam int IDLE_W = $clog2(WINDOW + 1);
  localparam logic [IDLE_W-1:0] IDLE_SAT = IDLE_W'(WINDOW);

  logic [PAGE_W-1:0] pageReg;
  logic              pageValid;
  logic [IDLE_W-1:0] idleCnt;
  logic              pageMatch;
  logic              inWindow;

  assign pageMatch = pageValid && (pageReg == pageIn);
  assign inWindow  = (idleCnt < IDLE_SAT);
  assign isHit     = pageMatch && inWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg   <= '0;
      pageValid <= 1'b0;
      idleCnt   <= IDLE_SAT;
    end else begin
      if (strobe.loadPage) begin
        pageReg   <= pageIn;
        pageValid <= 1'b1;
      end
      if (strobe.restartIdle) begin
        idleCnt <= '0;
      end else if (idleCnt != IDLE_SAT) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  // R6: idle count saturates at the window and never wraps
  a_r6_idle_bounded: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_SAT);

  // R6: a stale page never classifies as a hit
  a_r6_stale_is_miss: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == IDLE_SAT) |-> !isHit);

  // R7: a loaded page is open from the next cycle on
  a_r7_page_opened: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPage |=> pageValid);

endmodule

// File: rtl/page_latency_ctrl.sv
module page_latency_ctrl
  import page_latency_pkg::*;
#(
  parameter int RD_HIT_LAT  = 4,
  parameter int RD_MISS_LAT = 8,
  parameter int WR_LAT      = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         isHit,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         done,
  output logic         pageHit
);

  localparam int MAX_LAT = (RD_MISS_LAT > RD_HIT_LAT)
                         ? ((RD_MISS_LAT > WR_LAT) ? RD_MISS_LAT : WR_LAT)
                         : ((RD_HIT_LAT  > WR_LAT) ? RD_HIT_LAT  : WR_LAT);
  localparam int CNT_W = $clog2(MAX_LAT + 1);

  logic             busyQ;
  logic             doneQ;
  logic             hitQ;
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic [CNT_W-1:0] latSel;

  assign accept = reqValid && !busyQ;

  always_comb begin
    if (reqWrite)   latSel = CNT_W'(WR_LAT);
    else if (isHit) latSel = CNT_W'(RD_HIT_LAT);
    else            latSel = CNT_W'(RD_MISS_LAT);
  end

  always_comb begin
    strobe.loadPage    = accept;
    strobe.restartIdle = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      hitQ   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      doneQ  <= 1'b0;
      hitQ   <= isHit;
      remain <= latSel - 1'b1;
    end else if (busyQ) begin
      if (doneQ) begin
        busyQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (remain == CNT_W'(1)) begin
        doneQ  <= 1'b1;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign pageHit = doneQ && hitQ;

  // Checker-only bookkeeping: cycles since acceptance and the latency promised then.
  logic [CNT_W:0]   sinceAcc;
  logic [CNT_W-1:0] promisedLat;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAcc    <= '0;
      promisedLat <= '0;
    end else if (accept) begin
      sinceAcc    <= (CNT_W+1)'(1);
      promisedLat <= latSel;
    end else if (busyQ) begin
      sinceAcc <= sinceAcc + 1'b1;
    end
  end

  // R3 / R4 / R5: completion lands exactly on the latency chosen at acceptance
  a_r3_latency_met: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (sinceAcc == {1'b0, promisedLat}));

  // R10: completion strobe is a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: busy covers the completion cycle
  a_r9_busy_with_done: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> busyQ);

  // R8: an access in flight keeps running and keeps its result
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !doneQ) |=> (busyQ && $stable(hitQ)));

endmodule

// File: rtl/page_latency_tracker.sv
module page_latency_tracker
  import page_latency_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_LO     = 12,
  parameter int PAGE_HI     = 22,
  parameter int WINDOW      = 1024,
  parameter int RD_HIT_LAT  = 4,
  parameter int RD_MISS_LAT = 8,
  parameter int WR_LAT      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              busy,
  output logic              done,
  output logic              pageHit
);

  localparam int PAGE_W = PAGE_HI - PAGE_LO + 1;

  ctrl_strobe_t      strobe;
  logic              isHit;
  logic [PAGE_W-1:0] pageField;
  logic              unusedAddrBits;

  assign pageField      = reqAddr[PAGE_HI:PAGE_LO];
  assign unusedAddrBits = ^{reqAddr[ADDR_W-1:PAGE_HI+1], reqAddr[PAGE_LO-1:0]};

  page_latency_dp #(
    .PAGE_W (PAGE_W),
    .WINDOW (WINDOW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pageIn (pageField),
    .isHit  (isHit)
  );

  page_latency_ctrl #(
    .RD_HIT_LAT  (RD_HIT_LAT),
    .RD_MISS_LAT (RD_MISS_LAT),
    .WR_LAT      (WR_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .isHit    (isHit),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .pageHit  (pageHit)
  );

endmodule

// File: tb/page_latency_tracker_tb.sv
module page_latency_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        busy;
  logic        done;
  logic        pageHit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastAcc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_latency_tracker u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .busy     (busy),
    .done     (done),
    .pageHit  (pageHit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && pageHit == 0, "R1", "outputs in reset",
          {busy, done, pageHit}, 0);
    rstN = 1'b1;
  endtask

  // Issue one access 'gap' cycles after the previous acceptance edge (0 = at once)
  // and check latency, busy window, hit result and single-cycle done.
  task automatic access(input logic [31:0] a, input bit wr, input int gap,
                        input bit expHit, input int expLat, input bit hammer,
                        input string req);
    int doneAt = 0;
    int doneCount = 0;
    bit busyGap = 0;
    bit strayHit = 0;
    bit hitSeen = 0;
    bit busyAfter = 1;
    while (cyc + 1 - lastAcc < gap) @(negedge clk);
    reqAddr = a; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    lastAcc = cyc;
    for (int k = 1; k <= expLat + 1; k++) begin
      if (done) begin
        doneCount++;
        if (doneAt == 0) doneAt = k;
      end
      if (!done && pageHit) strayHit = 1;
      if (k <= expLat && !busy) busyGap = 1;
      if (k == expLat) hitSeen = pageHit;
      if (k == expLat + 1) busyAfter = busy;
      if (k == 1) begin
        reqValid = hammer;
        reqAddr  = hammer ? 32'h1234_7000 : a;
        reqWrite = 1'b0;
      end
      if (k == expLat) reqValid = 1'b0;
      if (k <= expLat) @(negedge clk);
    end
    check(doneAt == expLat, req, "done cycle after acceptance", doneAt, expLat);
    check(doneCount == 1, "R10", "done pulse count", doneCount, 1);
    check(hitSeen == expHit, req, "pageHit at done", hitSeen, expHit);
    check(!busyGap && !busyAfter, "R9", "busy window", {busyGap, busyAfter}, 0);
    check(!strayHit, "R10", "pageHit outside done", strayHit, 0);
  endtask

  task automatic testFirstMiss();      // R1, R4
    doReset();
    access(32'h0000_5000, 0, 0, 0, 8, 0, "R1");
  endtask

  task automatic testPageField();      // R2, R3, R4
    access(32'hFF80_5ABC, 0, 0, 1, 4, 0, "R3");
    access(32'h0000_6000, 0, 0, 0, 8, 0, "R4");
    access(32'h0040_6000, 0, 0, 0, 8, 0, "R2");
  endtask

  task automatic testWrites();         // R5, R7
    access(32'h0040_6004, 1, 0, 1, 2, 0, "R5");
    access(32'h0000_9000, 1, 0, 0, 2, 0, "R5");
    access(32'h0000_9FFC, 0, 0, 1, 4, 0, "R7");
  endtask

  task automatic testBusyIgnore();     // R8
    access(32'h0000_9000, 0, 0, 1, 4, 1, "R8");
    access(32'h0000_9000, 0, 0, 1, 4, 0, "R8");
  endtask

  task automatic testWindow();         // R6
    access(32'h0000_9000, 0, 1024, 1, 4, 0, "R6");
    access(32'h0000_9000, 0, 1025, 0, 8, 0, "R6");
    access(32'h0000_9000, 0, 0, 1, 4, 0, "R6");
    access(32'h0000_9000, 0, 5000, 0, 8, 0, "R6");
  endtask

  task automatic testResetClears();    // R1
    access(32'h0000_9000, 0, 0, 1, 4, 0, "R1");
    doReset();
    access(32'h0000_9000, 0, 0, 0, 8, 0, "R1");
  endtask

  initial begin
    testFirstMiss();
    testPageField();
    testWrites();
    testBusyIgnore();
    testWindow();
    testResetClears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule